// File: doc/BRIEF.md
# Interrupt Redirection Entry Controller

The block routes a set of interrupt input pins to a single delivery port facing the processor. Each pin has its own redirection entry. The entry holds an interrupt vector, a trigger mode (edge or level) and a mask bit. It also holds a remote-pending flag that software can read but cannot write. A level-triggered pin that has delivered stays blocked until the processor acknowledges it. Edge-triggered pins latch a rising edge and deliver it once.

Software reaches the entries indirectly. It first writes a pin/half selector to an index register, then reads or writes a 32-bit window onto the selected half of that pin's 64-bit entry. A separate end-of-interrupt register takes a vector and releases every level entry that carries it. That register exists only when the `VERSION` parameter is 0x20 or higher. On older versions the only way to release a stuck level entry is to write its trigger mode to edge and then back to level.

When several pins are ready in the same cycle, the lowest-numbered pin is offered first. The delivery port uses a valid/ready handshake. An offer is taken when valid and ready are both high at a clock edge.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry reads as masked, edge mode, vector 0, with no pending request and remote-pending clear, and `dlv_valid_o` is low.
- R2: Register address 0 is the index register. Bit 0 selects the half (0 = low, 1 = high) and bits [3:1] select the pin. Address 1 is the data window. The low word holds vector in [7:0], mask in [8], level mode in [9] (1 = level) and remote-pending in [10], with the other bits zero. The high word reads zero and ignores writes. Address 3 reads `VERSION` in [7:0] and NUM_PINS-1 in [23:16].
- R3: A handshake on a level-mode pin sets that entry's remote-pending flag. The flag then stays set until it is released (R6, R8).
- R4: While a level entry's remote-pending flag is set, that pin is not offered, even with its input still high.
- R5: Remote-pending cannot be written. Writing 0 or 1 to bit 10 of the low word leaves it unchanged.
- R6: A write of a vector to address 2 clears remote-pending on every level-mode entry whose vector matches. Entries whose vector differs keep their flag.
- R7: When `VERSION` is below 0x20, writes to address 2 have no effect.
- R8: Writing an entry's mode to edge clears its remote-pending flag. Writing level mode back afterwards leaves the flag clear.
- R9: A masked entry is never offered. Masking leaves remote-pending as it was.
- R10: In edge mode, a rising input edge is latched as a pending request, including while masked. The request is offered once the entry is unmasked and is cleared by its handshake. Edge entries never set remote-pending.
- R11: Among ready pins, the lowest-numbered one is offered, with its vector on `dlv_vec_o` and its number on `dlv_pin_o`. Exactly one request is consumed per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_PINS | Interrupt input pins, synchronous to clk_i |
| reg_addr_i | input | 2 | Register address: 0 index, 1 window, 2 end-of-interrupt, 3 info |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| dlv_valid_o | output | 1 | An interrupt is offered |
| dlv_ready_i | input | 1 | Processor accepts the offer |
| dlv_vec_o | output | 8 | Vector of the offered interrupt |
| dlv_pin_o | output | $clog2(NUM_PINS) | Pin number of the offered interrupt |

## Verification
The assertions assume that `irq_i` is already synchronous to `clk_i`. They also assume that software never writes an entry's mode or issues an end-of-interrupt for a pin in the same cycle that the pin is handed over. In those collisions the outcome follows a fixed priority that the properties do not cover. The stimulus keeps `dlv_ready_i` low around every register write that touches a pin that could be offered, and changes inputs only on the falling edge. A second instance with an old version number receives the same traffic, and the bench inspects its window to show that the end-of-interrupt write has no effect there.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W       = 8;
  localparam int EOI_MIN_VER = 8'h20;

  localparam logic [1:0] ADDR_INDEX  = 2'd0;
  localparam logic [1:0] ADDR_WINDOW = 2'd1;
  localparam logic [1:0] ADDR_EOI    = 2'd2;
  localparam logic [1:0] ADDR_INFO   = 2'd3;

  // packed order doubles as the low-word layout: {level, mask, vec}
  typedef struct packed {
    logic             level;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_cfg_t;

  localparam entry_cfg_t CFG_RESET = '{level: 1'b0, mask: 1'b1, vec: '0};
endpackage

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             wr_en_i,
  input  entry_cfg_t       wr_cfg_i,
  input  logic             eoi_en_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             grant_i,
  output logic             req_o,
  output entry_cfg_t       cfg_o,
  output logic             rpend_o
);
  entry_cfg_t cfg_q;
  logic irq_q, rpend_q, rpend_d, epend_q, epend_d, rise;

  assign rise = irq_i & ~irq_q;

  always_comb begin
    rpend_d = rpend_q;
    if (eoi_en_i && cfg_q.level && eoi_vec_i == cfg_q.vec) rpend_d = 1'b0;
    if (grant_i && cfg_q.level)                            rpend_d = 1'b1;
    if (wr_en_i && !wr_cfg_i.level)                        rpend_d = 1'b0;
  end

  always_comb begin
    epend_d = epend_q;
    if (grant_i && !cfg_q.level)   epend_d = 1'b0;
    if (rise && !cfg_q.level)      epend_d = 1'b1;
    if (wr_en_i && wr_cfg_i.level) epend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_RESET;
      irq_q   <= 1'b0;
      rpend_q <= 1'b0;
      epend_q <= 1'b0;
    end else begin
      if (wr_en_i) cfg_q <= wr_cfg_i;
      irq_q   <= irq_i;
      rpend_q <= rpend_d;
      epend_q <= epend_d;
    end
  end

  assign req_o   = !cfg_q.mask && (cfg_q.level ? (irq_i && !rpend_q) : epend_q);
  assign cfg_o   = cfg_q;
  assign rpend_o = rpend_q;

  // R3
  a_r3_level_grant_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && cfg_q.level && !(wr_en_i && !wr_cfg_i.level)) |=> rpend_q);
  // R4
  a_r4_blocked_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.level && rpend_q) |-> !req_o);
  // R5
  a_r5_set_only_by_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rpend_q) |-> $past(grant_i));
  // R6
  a_r6_eoi_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_en_i && cfg_q.level && eoi_vec_i == cfg_q.vec && !grant_i) |=> !rpend_q);
  // R8
  a_r8_edge_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_cfg_i.level) |=> !rpend_q);
  // R9
  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.mask |-> !req_o);
  a_r9_mask_keeps_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mask && rpend_q && !eoi_en_i && !wr_en_i) |=> rpend_q);
  // R10
  a_r10_edge_never_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.level && !rpend_q) |=> !rpend_q);
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        idx_o      = W'(i);
        any_o      = 1'b1;
      end
    end
  end

  // R11
  a_r11_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  a_r11_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> (((grant_o - N'(1)) & req_i) == '0));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h20,
  localparam int PIN_W = $clog2(NUM_PINS),
  localparam int IDX_W = PIN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  entry_cfg_t       cfg_i   [NUM_PINS],
  input  logic             rpend_i [NUM_PINS],
  output logic [NUM_PINS-1:0] wr_en_o,
  output entry_cfg_t       wr_cfg_o,
  output logic             eoi_en_o,
  output logic [VEC_W-1:0] eoi_vec_o
);
  logic [IDX_W-1:0] idx_q;
  logic [PIN_W-1:0] sel_pin;
  logic             sel_hi, pin_ok, win_wr;
  logic             unused_wdata;

  assign sel_pin = idx_q[IDX_W-1:1];
  assign sel_hi  = idx_q[0];
  assign pin_ok  = int'(sel_pin) < NUM_PINS;
  assign win_wr  = we_i && addr_i == ADDR_WINDOW && !sel_hi && pin_ok;
  assign unused_wdata = ^wdata_i[31:VEC_W+2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           idx_q <= '0;
    else if (we_i && addr_i == ADDR_INDEX) idx_q <= wdata_i[IDX_W-1:0];
  end

  assign wr_cfg_o  = entry_cfg_t'(wdata_i[VEC_W+1:0]);
  assign eoi_vec_o = wdata_i[VEC_W-1:0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_wr
    assign wr_en_o[p] = win_wr && sel_pin == PIN_W'(p);
  end

  if (VERSION >= EOI_MIN_VER) begin : g_eoi
    assign eoi_en_o = we_i && addr_i == ADDR_EOI;
  end else begin : g_no_eoi
    assign eoi_en_o = 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_INDEX:  rdata_o = 32'(idx_q);
      ADDR_WINDOW: if (!sel_hi && pin_ok)
                     rdata_o = 32'({rpend_i[sel_pin], cfg_i[sel_pin]});
      ADDR_INFO:   rdata_o = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
      default:     rdata_o = '0;
    endcase
  end

  // R2
  a_r2_one_entry_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  // R7
  a_r7_old_version_no_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (VERSION < EOI_MIN_VER) |-> !eoi_en_o);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PINS-1:0]         irq_i,
  input  logic [1:0]                  reg_addr_i,
  input  logic                        reg_we_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  output logic                        dlv_valid_o,
  input  logic                        dlv_ready_i,
  output logic [7:0]                  dlv_vec_o,
  output logic [$clog2(NUM_PINS)-1:0] dlv_pin_o
);
  localparam int PIN_W = $clog2(NUM_PINS);

  entry_cfg_t          cfg     [NUM_PINS];
  logic                rpend   [NUM_PINS];
  logic [NUM_PINS-1:0] req, grant, wr_en;
  entry_cfg_t          wr_cfg;
  logic                eoi_en, any, hs;
  logic [VEC_W-1:0]    eoi_vec;
  logic [PIN_W-1:0]    win_pin;

  irq_route_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cfg_i(cfg), .rpend_i(rpend),
    .wr_en_o(wr_en), .wr_cfg_o(wr_cfg), .eoi_en_o(eoi_en), .eoi_vec_o(eoi_vec)
  );

  irq_route_arb #(.N(NUM_PINS)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .grant_o(grant), .any_o(any), .idx_o(win_pin)
  );

  assign hs = any && dlv_ready_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
    irq_route_entry u_entry (
      .clk_i, .rst_ni,
      .irq_i(irq_i[p]), .wr_en_i(wr_en[p]), .wr_cfg_i(wr_cfg),
      .eoi_en_i(eoi_en), .eoi_vec_i(eoi_vec),
      .grant_i(grant[p] && hs),
      .req_o(req[p]), .cfg_o(cfg[p]), .rpend_o(rpend[p])
    );
  end

  assign dlv_valid_o = any;
  assign dlv_pin_o   = win_pin;
  assign dlv_vec_o   = any ? cfg[win_pin].vec : '0;

  // R11
  a_r11_offer_is_ready_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (!cfg[dlv_pin_o].mask && req[dlv_pin_o]));
  // R1
  a_r1_no_offer_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !dlv_valid_o);
endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;
  localparam int NP    = 8;
  localparam int PW    = $clog2(NP);
  localparam int IW    = PW + 1;
  localparam logic [7:0] VER_NEW = 8'h20;
  localparam logic [7:0] VER_OLD = 8'h11;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] irq = '0;
  logic [1:0]    addr = 2'd0;
  logic          we = 1'b0, ready = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata_old;
  logic          valid, valid_old;
  logic [7:0]    vec, vec_old;
  logic [PW-1:0] pin, pin_old;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_ctrl #(.NUM_PINS(NP), .VERSION(VER_NEW)) u_irq_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dlv_valid_o(valid),
    .dlv_ready_i(ready), .dlv_vec_o(vec), .dlv_pin_o(pin));

  irq_route_ctrl #(.NUM_PINS(NP), .VERSION(VER_OLD)) u_irq_route_ctrl_v11 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_old), .dlv_valid_o(valid_old),
    .dlv_ready_i(ready), .dlv_vec_o(vec_old), .dlv_pin_o(pin_old));

  // behavioural reference (new-version instance)
  int m_vec[NP], m_mask[NP], m_lvl[NP], m_rp[NP], m_ep[NP], m_prev[NP];
  int m_idx;

  function automatic int m_ready(int p);
    if (m_mask[p] != 0) return 0;
    if (m_lvl[p] != 0)  return (irq[p] && m_rp[p] == 0) ? 1 : 0;
    return m_ep[p];
  endfunction

  function automatic int m_pick();
    for (int p = 0; p < NP; p++) if (m_ready(p) != 0) return p;
    return -1;
  endfunction

  function automatic logic [31:0] m_rdata();
    int p = m_idx / 2;
    case (addr)
      2'd0: return 32'(m_idx);
      2'd1: if ((m_idx % 2) == 0 && p < NP)
              return 32'((m_rp[p] << 10) | (m_lvl[p] << 9) | (m_mask[p] << 8) | m_vec[p]);
            else return 32'h0;
      2'd3: return {8'h00, 8'(NP - 1), 8'h00, VER_NEW};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_vec[p] = 0; m_mask[p] = 1; m_lvl[p] = 0; m_rp[p] = 0; m_ep[p] = 0; m_prev[p] = 0;
      end
      m_idx = 0;
    end else begin
      int g;
      int wp;
      g  = ready ? m_pick() : -1;
      wp = (we && addr == 2'd1 && (m_idx % 2) == 0) ? m_idx / 2 : -1;
      for (int p = 0; p < NP; p++) begin
        int rp, ep, rise;
        rp = m_rp[p]; ep = m_ep[p];
        rise = (irq[p] && m_prev[p] == 0) ? 1 : 0;
        if (we && addr == 2'd2 && m_lvl[p] != 0 && m_vec[p] == int'(wdata[7:0])) rp = 0;
        if (g == p) begin
          if (m_lvl[p] != 0) rp = 1; else ep = 0;
        end
        if (rise != 0 && m_lvl[p] == 0) ep = 1;
        if (wp == p) begin
          if (wdata[9]) ep = 0; else rp = 0;
          m_vec[p] = int'(wdata[7:0]); m_mask[p] = int'(wdata[8]); m_lvl[p] = int'(wdata[9]);
        end
        m_rp[p] = rp; m_ep[p] = ep; m_prev[p] = irq[p] ? 1 : 0;
      end
      if (we && addr == 2'd0) m_idx = int'(wdata[IW-1:0]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int g;
      g = m_pick();
      chk("R11 valid", 32'(valid), (g >= 0) ? 32'd1 : 32'd0);
      if (g >= 0) begin
        chk("R11 vector", 32'(vec), 32'(m_vec[g]));
        chk("R11 pin", 32'(pin), 32'(g));
      end
      chk("R2 rdata", rdata, m_rdata());
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic sel(input int p, input int hi);
    reg_wr(2'd0, 32'(p * 2 + hi));
    addr = 2'd1;
    #2;
  endtask

  task automatic pulse_ready();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid after reset", 32'(valid), 32'd0);
    sel(3, 0);
    chk("R1 entry reset value", rdata, 32'h0000_0100);
    addr = 2'd3; #1;
    chk("R2 info word", rdata, {8'h00, 8'(NP - 1), 8'h00, VER_NEW});
    sel(3, 1);
    chk("R2 high word zero", rdata, 32'h0);

    // level pin 2, vector 0x42
    sel(2, 0);
    reg_wr(2'd1, 32'h0000_0242);
    irq[2] = 1'b1; #1;
    chk("R3 offer valid", 32'(valid), 32'd1);
    chk("R3 offer vector", 32'(vec), 32'h42);
    chk("R11 offer pin", 32'(pin), 32'd2);
    ready = 1'b1;
    @(negedge clk); ready = 1'b0; #1;
    chk("R4 blocked while pending", 32'(valid), 32'd0);
    addr = 2'd1; #1;
    chk("R3 pending set", rdata, 32'h0000_0642);

    reg_wr(2'd1, 32'h0000_0242);
    addr = 2'd1; #1;
    chk("R5 write 0 ignored", rdata, 32'h0000_0642);

    reg_wr(2'd2, 32'h43);
    addr = 2'd1; #1;
    chk("R6 other vector keeps", rdata, 32'h0000_0642);
    reg_wr(2'd2, 32'h42);
    addr = 2'd1; #1;
    chk("R6 matching vector clears", rdata, 32'h0000_0242);
    chk("R6 redelivery offered", 32'(valid), 32'd1);
    chk("R7 old version keeps", rdata_old, 32'h0000_0642);
    chk("R7 old version quiet", 32'(valid_old), 32'd0);

    pulse_ready();
    addr = 2'd1; #1;
    chk("R3 pending again", rdata, 32'h0000_0642);
    reg_wr(2'd1, 32'h0000_0042);
    addr = 2'd1; #1;
    chk("R8 edge clears", rdata, 32'h0000_0042);
    chk("R8 edge clears (old)", rdata_old, 32'h0000_0042);
    reg_wr(2'd1, 32'h0000_0242);
    addr = 2'd1; #1;
    chk("R8 back to level clear", rdata, 32'h0000_0242);
    chk("R8 back to level (old)", rdata_old, 32'h0000_0242);

    pulse_ready();
    reg_wr(2'd1, 32'h0000_0342);
    addr = 2'd1; #1;
    chk("R9 mask keeps pending", rdata, 32'h0000_0742);
    chk("R9 masked no offer", 32'(valid), 32'd0);
    reg_wr(2'd1, 32'h0000_0742);
    addr = 2'd1; #1;
    chk("R5 write 1 ignored", rdata, 32'h0000_0742);
    @(negedge clk); irq[2] = 1'b0;

    // edge pin 6, masked while the edge arrives
    sel(6, 0);
    reg_wr(2'd1, 32'h0000_0166);
    irq[6] = 1'b1;
    @(negedge clk); irq[6] = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 masked edge held", 32'(valid), 32'd0);
    reg_wr(2'd1, 32'h0000_0066);
    #1;
    chk("R10 edge offered", 32'(valid), 32'd1);
    chk("R10 edge vector", 32'(vec), 32'h66);
    pulse_ready();
    #1;
    chk("R10 consumed once", 32'(valid), 32'd0);
    addr = 2'd1; #1;
    chk("R10 no remote pending", rdata, 32'h0000_0066);

    // two edge pins at once
    sel(1, 0);
    reg_wr(2'd1, 32'h0000_0011);
    sel(4, 0);
    reg_wr(2'd1, 32'h0000_0044);
    irq[1] = 1'b1; irq[4] = 1'b1;
    @(negedge clk); irq[1] = 1'b0; irq[4] = 1'b0; #1;
    chk("R11 lowest first", 32'(pin), 32'd1);
    chk("R11 lowest vector", 32'(vec), 32'h11);
    ready = 1'b1;
    @(negedge clk); #1;
    chk("R11 next pin", 32'(pin), 32'd4);
    @(negedge clk); ready = 1'b0; #1;
    chk("R11 drained", 32'(valid), 32'd0);

    sel(4, 1);
    reg_wr(2'd1, 32'hFFFF_FFFF);
    addr = 2'd1; #1;
    chk("R2 high write ignored", rdata, 32'h0);
    sel(4, 0);
    chk("R2 low word intact", rdata, 32'h0000_0044);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule